// File: doc/BRIEF.md
# Load-Load Ordering Violation Queue

This block tracks loads that executed ahead of older loads, so that a later coherence event on the same cache line can be detected as a load-load ordering hazard. Each load that executes (each half of a split load) allocates one record. A record holds a 16-bit hash of the cache-line address, the load's age and a released flag. A probe or eviction of the line sets the released flag of every matching record. An older load queries the records while it executes. If it finds a younger, released record with the same hash, the block requests a pipeline rollback one cycle later.

A full queue does not stall the load pipeline. The load that could not allocate receives a rollback with a full cause and is re-executed later. The hash is written into an entry one cycle after allocation. During that cycle a bypass register holds the pending hash, so probes and queries still see it. Commit frees every record of the committing age, which covers both halves of a split load. A flush drops every record younger than the flush point in the same cycle.

Top module: `llv_queue`

## Requirements
- R1: After reset the queue is empty, and rb_valid_o, rb_viol_o and rb_full_o are 0.
- R2: A load with enq_pf_i=1 neither allocates an entry nor queries, and never causes a rollback.
- R3: The tag is the XOR fold of line address bits paddr[47:6]: hash bit k is the XOR of paddr[6+j] for all j with j mod 16 = k. Matching uses only this 16-bit hash, so lines that alias in the hash match each other.
- R4: A query (enq_valid_i=1, enq_pf_i=0) hits an entry that is valid, younger than the querying load, released and hash-equal. On a hit, the next cycle shows rb_valid_o=1, rb_viol_o=1 and rb_age_o equal to the query age.
- R5: A valid entry does not cause a rollback if it is not younger than the querying load, has a different hash, or is not released.
- R6: A probe sets the released flag of matching entries. This includes a probe in the same cycle as the allocation and a probe in the following cycle, while the hash write is still pending.
- R7: Each half of a split load allocates its own entry under the same age. 36 split loads (72 allocations) fill a 72-entry queue.
- R8: If all entries are valid, a non-prefetch load is not stored. The next cycle shows rb_valid_o=1 and rb_full_o=1.
- R9: commit_valid_i frees every entry whose age equals commit_age_i. The freed space can be allocated in the following cycle.
- R10: flush_valid_i invalidates, in the same cycle, every entry that is younger than flush_age_i. An incoming load younger than flush_age_i in that cycle neither allocates nor queries.
- R11: An age is {wrap, index} (bit 7 is the wrap bit). a is younger than b when the wrap bits are equal and a.index > b.index, or when the wrap bits differ and a.index < b.index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | A load (half) executes: query and allocate |
| enq_pf_i | input | 1 | The request is a prefetch |
| enq_age_i | input | 8 | Age of the executing load |
| enq_paddr_i | input | 48 | Physical address of the executing load |
| probe_valid_i | input | 1 | A line is probed or evicted |
| probe_paddr_i | input | 48 | Address of the probed line |
| commit_valid_i | input | 1 | A load commits |
| commit_age_i | input | 8 | Age of the committing load |
| flush_valid_i | input | 1 | Redirect flush |
| flush_age_i | input | 8 | Flush point; younger entries are dropped |
| rb_valid_o | output | 1 | Rollback request |
| rb_age_o | output | 8 | Age of the load to roll back |
| rb_viol_o | output | 1 | Cause: ordering violation |
| rb_full_o | output | 1 | Cause: queue full |

## Verification
The two functions most likely to meet in one cycle are allocation and release: a probe may arrive in the same cycle as a load's allocation or in the following cycle, while its hash write is pending. Directed sequences place the probe in each of those two cycles, then issue an older query. A missing rollback on that query shows that the flag was lost. Random stimulus also mixes flushes, commits and probes with allocation. A bench model keeps the hash at allocation time, so it has no bypass path, and it predicts every rollback output cycle by cycle.

// File: rtl/llv_pkg.sv
`timescale 1ns/1ps
package llv_pkg;
  parameter int PA_W     = 48;
  parameter int HASH_W   = 16;
  parameter int LINE_OFF = 6;

  // xor fold of the line address
  function automatic logic [HASH_W-1:0] line_hash(input logic [PA_W-1:0] pa);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int b = LINE_OFF; b < PA_W; b++) h[(b-LINE_OFF)%HASH_W] ^= pa[b];
    return h;
  endfunction
endpackage

// File: rtl/llv_free_pick.sv
`timescale 1ns/1ps
module llv_free_pick #(
  parameter int DEPTH = 72,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             full_o
);
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (!busy_i[i]) idx_o = IDX_W'(i);
  end
  assign full_o = &busy_i;
endmodule

// File: rtl/llv_entry.sv
`timescale 1ns/1ps
module llv_entry #(
  parameter int AGE_W  = 8,
  parameter int HASH_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [AGE_W-1:0]  alloc_age_i,
  input  logic [HASH_W-1:0] alloc_hash_i,
  input  logic              pend_i,
  input  logic [HASH_W-1:0] pend_hash_i,
  input  logic              probe_valid_i,
  input  logic [HASH_W-1:0] probe_hash_i,
  input  logic              commit_valid_i,
  input  logic [AGE_W-1:0]  commit_age_i,
  input  logic              flush_valid_i,
  input  logic [AGE_W-1:0]  flush_age_i,
  input  logic              qry_i,
  input  logic [AGE_W-1:0]  qry_age_i,
  input  logic [HASH_W-1:0] qry_hash_i,
  output logic              vld_o,
  output logic              viol_o
);
  function automatic logic younger(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    if (a[AGE_W-1] != b[AGE_W-1]) return a[AGE_W-2:0] < b[AGE_W-2:0];
    return a[AGE_W-2:0] > b[AGE_W-2:0];
  endfunction

  logic              vld_q, rel_q;
  logic [AGE_W-1:0]  age_q;
  logic [HASH_W-1:0] hash_q, eff_hash;
  logic              kill;

  // hash lands one cycle after alloc; bypass covers that cycle
  assign eff_hash = pend_i ? pend_hash_i : hash_q;
  assign kill = (commit_valid_i && age_q == commit_age_i) ||
                (flush_valid_i && younger(age_q, flush_age_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      rel_q  <= 1'b0;
      age_q  <= '0;
      hash_q <= '0;
    end else begin
      if (alloc_i) begin
        vld_q <= 1'b1;
        age_q <= alloc_age_i;
        rel_q <= probe_valid_i && probe_hash_i == alloc_hash_i;
      end else begin
        if (vld_q && kill) vld_q <= 1'b0;
        if (vld_q && probe_valid_i && probe_hash_i == eff_hash) rel_q <= 1'b1;
      end
      if (pend_i) hash_q <= pend_hash_i;
    end
  end

  assign vld_o  = vld_q;
  assign viol_o = qry_i && vld_q && rel_q && younger(age_q, qry_age_i) &&
                  eff_hash == qry_hash_i;
endmodule

// File: rtl/llv_queue.sv
`timescale 1ns/1ps
module llv_queue
  import llv_pkg::*;
#(
  parameter int DEPTH = 72,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AGE_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  input  logic             enq_pf_i,
  input  logic [AGE_W-1:0] enq_age_i,
  input  logic [PA_W-1:0]  enq_paddr_i,
  input  logic             probe_valid_i,
  input  logic [PA_W-1:0]  probe_paddr_i,
  input  logic             commit_valid_i,
  input  logic [AGE_W-1:0] commit_age_i,
  input  logic             flush_valid_i,
  input  logic [AGE_W-1:0] flush_age_i,
  output logic             rb_valid_o,
  output logic [AGE_W-1:0] rb_age_o,
  output logic             rb_viol_o,
  output logic             rb_full_o
);
  function automatic logic younger(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    if (a[AGE_W-1] != b[AGE_W-1]) return a[AGE_W-2:0] < b[AGE_W-2:0];
    return a[AGE_W-2:0] > b[AGE_W-2:0];
  endfunction

  logic [DEPTH-1:0]  vld_vec, viol_vec;
  logic [HASH_W-1:0] enq_hash, probe_hash, pend_hash_q;
  logic [IDX_W-1:0]  free_idx, pend_idx_q;
  logic              full, qry, alloc, pend_vld_q;

  assign enq_hash   = line_hash(enq_paddr_i);
  assign probe_hash = line_hash(probe_paddr_i);
  assign qry   = enq_valid_i && !enq_pf_i &&
                 !(flush_valid_i && younger(enq_age_i, flush_age_i));
  assign alloc = qry && !full;

  llv_free_pick #(.DEPTH(DEPTH)) u_pick (
    .busy_i(vld_vec), .idx_o(free_idx), .full_o(full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    llv_entry #(.AGE_W(AGE_W), .HASH_W(HASH_W)) u_ent (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .alloc_i(alloc && free_idx == IDX_W'(g)),
      .alloc_age_i(enq_age_i), .alloc_hash_i(enq_hash),
      .pend_i(pend_vld_q && pend_idx_q == IDX_W'(g)), .pend_hash_i(pend_hash_q),
      .probe_valid_i(probe_valid_i), .probe_hash_i(probe_hash),
      .commit_valid_i(commit_valid_i), .commit_age_i(commit_age_i),
      .flush_valid_i(flush_valid_i), .flush_age_i(flush_age_i),
      .qry_i(qry), .qry_age_i(enq_age_i), .qry_hash_i(enq_hash),
      .vld_o(vld_vec[g]), .viol_o(viol_vec[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_idx_q  <= '0;
      pend_hash_q <= '0;
      rb_valid_o  <= 1'b0;
      rb_viol_o   <= 1'b0;
      rb_full_o   <= 1'b0;
      rb_age_o    <= '0;
    end else begin
      pend_vld_q <= alloc;
      if (alloc) begin
        pend_idx_q  <= free_idx;
        pend_hash_q <= enq_hash;
      end
      rb_valid_o <= qry && (full || |viol_vec);
      rb_viol_o  <= qry && |viol_vec;
      rb_full_o  <= qry && full;
      rb_age_o   <= enq_age_i;
    end
  end
endmodule

// File: rtl/llv_queue_chk.sv
`timescale 1ns/1ps
module llv_queue_chk #(
  parameter int DEPTH = 72
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enq_valid_i,
  input logic             enq_pf_i,
  input logic             commit_valid_i,
  input logic             flush_valid_i,
  input logic [DEPTH-1:0] vld_vec,
  input logic             rb_valid_o,
  input logic             rb_full_o
);
  // R2
  pf_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_valid_i && enq_pf_i) |=> $countones(vld_vec) <= $past($countones(vld_vec)));
  // R8
  full_rb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_valid_i && !enq_pf_i && !flush_valid_i && &vld_vec) |=> (rb_valid_o && rb_full_o));
  // R8
  full_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_full_o |-> $past(&vld_vec));
  // R4
  rb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_o |-> $past(enq_valid_i && !enq_pf_i));
  // R9
  commit_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && !enq_valid_i) |=> $countones(vld_vec) <= $past($countones(vld_vec)));
endmodule

bind llv_queue llv_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enq_valid_i(enq_valid_i), .enq_pf_i(enq_pf_i),
  .commit_valid_i(commit_valid_i), .flush_valid_i(flush_valid_i), .vld_vec(vld_vec),
  .rb_valid_o(rb_valid_o), .rb_full_o(rb_full_o)
);

// File: tb/sim_llv_queue.sv
`timescale 1ns/1ps
module sim_llv_queue;
  import llv_pkg::*;
  localparam int DEPTH = 72;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enq_valid, enq_pf, probe_valid, commit_valid, flush_valid;
  logic [7:0] enq_age, commit_age, flush_age;
  logic [47:0] enq_paddr, probe_paddr;
  logic rb_valid_o, rb_viol_o, rb_full_o;
  logic [7:0] rb_age_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_vld[DEPTH];
  bit m_rel[DEPTH];
  logic [7:0] m_age[DEPTH];
  logic [15:0] m_hash[DEPTH];
  logic e_v, e_viol, e_full;
  logic [7:0] e_age;

  always #2 clk = ~clk;

  llv_queue #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .enq_valid_i(enq_valid), .enq_pf_i(enq_pf),
    .enq_age_i(enq_age), .enq_paddr_i(enq_paddr), .probe_valid_i(probe_valid),
    .probe_paddr_i(probe_paddr), .commit_valid_i(commit_valid), .commit_age_i(commit_age),
    .flush_valid_i(flush_valid), .flush_age_i(flush_age), .rb_valid_o(rb_valid_o),
    .rb_age_o(rb_age_o), .rb_viol_o(rb_viol_o), .rb_full_o(rb_full_o)
  );

  // R11 age order
  function automatic bit yng(logic [7:0] a, logic [7:0] b);
    return (a[7] != b[7]) ? (a[6:0] < b[6:0]) : (a[6:0] > b[6:0]);
  endfunction
  // R3 hash
  function automatic logic [15:0] hsh(logic [47:0] pa);
    logic [15:0] h = '0;
    for (int j = 0; j < 42; j++) h[j%16] ^= pa[6+j];
    return h;
  endfunction

  task automatic idle();
    enq_valid = 0; enq_pf = 0; probe_valid = 0; commit_valid = 0; flush_valid = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 0;
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_rel[i] = 0; end
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  // apply driven inputs for one cycle, check against the model
  task automatic cyc(input string tag);
    bit qv, full, viol, placed;
    int cnt;
    logic [15:0] qh, ph;
    qh = hsh(enq_paddr); ph = hsh(probe_paddr);
    qv = enq_valid && !enq_pf && !(flush_valid && yng(enq_age, flush_age));
    cnt = 0; viol = 0;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i]) begin
        cnt++;
        if (m_rel[i] && yng(m_age[i], enq_age) && m_hash[i] == qh) viol = 1;
      end
    full = (cnt == DEPTH);
    e_v = qv && (viol || full); e_viol = qv && viol; e_full = qv && full; e_age = enq_age;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i]) begin
        if (probe_valid && m_hash[i] == ph) m_rel[i] = 1;
        if ((commit_valid && m_age[i] == commit_age) || (flush_valid && yng(m_age[i], flush_age)))
          m_vld[i] = 0;
      end
    placed = 0;
    if (qv && !full)
      for (int i = 0; i < DEPTH; i++)
        if (!placed && !m_vld[i]) begin
          placed = 1; m_vld[i] = 1; m_age[i] = enq_age; m_hash[i] = qh;
          m_rel[i] = probe_valid && ph == qh;
        end
    @(negedge clk);
    checks++;
    if (rb_valid_o !== e_v || (e_v && (rb_viol_o !== e_viol || rb_full_o !== e_full ||
        rb_age_o !== e_age))) begin
      errors++;
      $display("FAIL %s: rb v/viol/full/age=%b/%b/%b/%h expected %b/%b/%b/%h", tag,
               rb_valid_o, rb_viol_o, rb_full_o, rb_age_o, e_v, e_viol, e_full, e_age);
    end
    idle();
  endtask

  task automatic expect_rb(input logic v, input logic viol, input logic full, input string tag);
    checks++;
    if (rb_valid_o !== v || (v && (rb_viol_o !== viol || rb_full_o !== full))) begin
      errors++;
      $display("FAIL %s: rb v/viol/full=%b/%b/%b expected %b/%b/%b", tag,
               rb_valid_o, rb_viol_o, rb_full_o, v, viol, full);
    end
  endtask

  task automatic enq(input logic [7:0] age, input logic [47:0] pa);
    enq_valid = 1; enq_age = age; enq_paddr = pa;
  endtask
  task automatic prb(input logic [47:0] pa);
    probe_valid = 1; probe_paddr = pa;
  endtask

  localparam logic [47:0] LA = 48'h1000_0040, LB = 48'h2000_0080, LC = 48'h3000_00c0;

  initial begin
    enq_age = 0; enq_paddr = 0; probe_paddr = 0; commit_age = 0; flush_age = 0;
    do_reset();
    // R1
    cyc("R1"); expect_rb(0, 0, 0, "R1");
    // R6 probe during pending hash write, then R4 older query
    enq(8'd10, LA); cyc("R6");
    prb(LA); cyc("R6");
    enq(8'd5, LA + 8); cyc("R4"); expect_rb(1, 1, 0, "R4 bypass probe");
    checks++;
    if (rb_age_o !== 8'd5) begin errors++; $display("FAIL R4: age=%h expected 05", rb_age_o); end
    // R6 probe in the allocation cycle
    do_reset();
    enq(8'd20, LB); prb(LB); cyc("R6");
    enq(8'd3, LB); cyc("R6"); expect_rb(1, 1, 0, "R6 same-cycle probe");
    // R5 cases
    do_reset();
    enq(8'd10, LA); prb(LA); cyc("R5");
    enq(8'd12, LA); cyc("R5"); expect_rb(0, 0, 0, "R5 not younger");
    enq(8'd5, LC); cyc("R5"); expect_rb(0, 0, 0, "R5 other hash");
    enq(8'd30, LB); cyc("R5");
    enq(8'd4, LB); cyc("R5"); expect_rb(0, 0, 0, "R5 not released");
    // R11 wrap
    do_reset();
    enq({1'b1, 7'd2}, LA); prb(LA); cyc("R11");
    enq({1'b0, 7'd1}, LA); cyc("R11"); expect_rb(0, 0, 0, "R11 wrap older");
    enq({1'b0, 7'd70}, LA); cyc("R11"); expect_rb(1, 1, 0, "R11 wrap younger");
    // R3 aliasing: pa bit 6 and pa bit 22 fold into hash bit 0
    do_reset();
    enq(8'd10, 48'h40); prb(48'h40); cyc("R3");
    enq(8'd5, 48'h80); cyc("R3"); expect_rb(0, 0, 0, "R3 distinct hash");
    enq(8'd5, 48'h40_0000); cyc("R3"); expect_rb(1, 1, 0, "R3 alias");
    // R2 prefetch
    do_reset();
    enq(8'd10, LA); prb(LA); cyc("R2");
    enq(8'd5, LA); enq_pf = 1; cyc("R2"); expect_rb(0, 0, 0, "R2 pf query");
    for (int i = 0; i < DEPTH; i++) begin enq(8'(i), 48'(i) << 6); enq_pf = 1; cyc("R2"); end
    enq(8'd100, LC); cyc("R2"); expect_rb(0, 0, 0, "R2 pf no alloc");
    // R8 / R9
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin enq({1'b0, 7'(i)}, 48'(i) << 6); cyc("R8"); end
    enq(8'h80, LC); cyc("R8"); expect_rb(1, 0, 1, "R8 full");
    commit_valid = 1; commit_age = 8'd0; cyc("R9");
    enq(8'h81, LC); cyc("R9"); expect_rb(0, 0, 0, "R9 freed slot");
    enq(8'h82, LC); cyc("R8"); expect_rb(1, 0, 1, "R8 full again");
    // R7 split loads
    do_reset();
    enq(8'd9, LA); cyc("R7");
    enq(8'd9, LA + 64); prb(LA + 64); cyc("R7");
    enq(8'd3, LA + 64); cyc("R7"); expect_rb(1, 1, 0, "R7 second half");
    commit_valid = 1; commit_age = 8'd9; cyc("R9");
    enq(8'd3, LA + 64); cyc("R9"); expect_rb(0, 0, 0, "R9 both halves freed");
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin enq(8'(i / 2), 48'(i) << 6); cyc("R7"); end
    enq(8'd50, LC); cyc("R7"); expect_rb(1, 0, 1, "R7 36 split loads fill");
    // R10 flush
    do_reset();
    enq(8'd10, LA); prb(LA); cyc("R10");
    enq(8'd20, LB); prb(LB); cyc("R10");
    flush_valid = 1; flush_age = 8'd15; cyc("R10");
    enq(8'd5, LB); cyc("R10"); expect_rb(0, 0, 0, "R10 younger dropped");
    enq(8'd5, LA); cyc("R10"); expect_rb(1, 1, 0, "R10 older kept");
    enq(8'd40, LB); prb(LB); flush_valid = 1; flush_age = 8'd15; cyc("R10");
    expect_rb(0, 0, 0, "R10 killed load");
    enq(8'd5, LB); cyc("R10"); expect_rb(0, 0, 0, "R10 killed load not stored");
    // random mix
    do_reset();
    void'($urandom(32'h5eed));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 2 == 0) begin
        enq(8'($urandom), (48'($urandom % 6) << 6) | 48'($urandom % 64));
        enq_pf = ($urandom % 8 == 0);
      end
      if ($urandom % 4 == 0) prb(48'($urandom % 6) << 6);
      if ($urandom % 6 == 0) begin commit_valid = 1; commit_age = 8'($urandom); end
      if ($urandom % 24 == 0) begin flush_valid = 1; flush_age = 8'($urandom); end
      cyc("R4 R6 R8 R10 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule